// File: doc/BRIEF.md
# SD Card Clock Divider Control

This block is the clock-control register and card-clock generator of an SD host controller. Software writes a 16-bit control word that holds an internal-clock enable, a card-clock enable and a 10-bit divisor field. The block answers with a read-only "stable" flag that rises a fixed, parameterised number of base-clock cycles after the internal clock is enabled. The card clock runs only when the internal clock reads stable and the card-clock enable is set.

The divisor is read in one of two ways, chosen by a mode input. In extended mode the whole 10-bit value N gives a ratio of 2N, and N = 0 passes the base clock straight through. In legacy mode only the low eight divisor bits count, and the ratio is twice the largest power of two that does not exceed the field. Every divided output has equal high and low phases. A new divisor is taken up only at the end of a low phase, so the card clock never shows a shortened pulse.

Top module: `cardclk_gen`

## Requirements
- R1: After reset the control readback is 0x0000 and the card clock is low.
- R2: Readback layout: bit 0 internal enable, bit 1 stable, bit 2 card enable, bits [7:6] divisor high part, bits [15:8] divisor low part. Bits [5:3] always read 0. The stable bit ignores writes.
- R3: The stable bit reads 1 exactly STABLE_CYCLES base-clock edges after the edge that wrote the internal enable to 1.
- R4: A write that clears the internal enable makes the stable bit read 0 immediately after that write edge.
- R5: The card clock stays low while the card enable is set but the stable bit still reads 0.
- R6: In extended mode (mode input 1) with divisor N from 1 to 1023, the card clock is high for N base cycles and low for N base cycles. N combines the high part (bits [9:8] of N) and the low part.
- R7: In extended mode with N = 0, the card clock follows the base clock: high while the base clock is high and low while it is low.
- R8: In legacy mode (mode input 0) the high divisor part is ignored. A power-of-two low field F gives phases of F base cycles, and F = 0 passes the base clock through.
- R9: In legacy mode a low field that is not a power of two is rounded down to its highest set bit (0x06 acts as 4, 0x81 acts as 128).
- R10: A divisor written while the card clock is high takes effect only after the low phase that follows: that low phase keeps the old length and the next high phase has the new length.
- R11: Writing 0x0000 clears the readback to zero, and the card clock stays low once the high phase in progress has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 = extended 10-bit divisor, 0 = legacy power-of-two divisor |
| wr_en | input | 1 | Writes wr_data into the control register at the clock edge |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control register readback, including the stable flag |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
A stabilisation counter that is off by one moves the edge where the stable bit first reads 1, and the bench counts exactly that edge. A broken phase counter or a wrong divisor decode shows up on the first complete high and low phases of the card clock, within 2N base cycles. If the running divisor is reloaded at the wrong moment, the phase in which the write lands comes out too short, or the low phase after it takes the new length. Loss of gating shows as a card-clock edge while the stable readback is still 0, or after the control word has been cleared.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
   localparam int CTRL_W      = 16;
   localparam int DIV_LO_W    = 8;
   localparam int DIV_HI_W    = 2;
   localparam int DIV_W       = DIV_LO_W + DIV_HI_W;
   // bit positions of the control word; the divisor split is decoded by the generator
   localparam int POS_INT_EN  = 0;
   localparam int POS_STABLE  = 1;
   localparam int POS_CARD_EN = 2;
   localparam int POS_DIV_HI  = 6;
   localparam int POS_DIV_LO  = 8;
endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
   import cardclk_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   input  logic                stable_in,
   output logic                int_en,
   output logic                card_en,
   output logic [DIV_LO_W-1:0] div_lo,
   output logic [DIV_HI_W-1:0] div_hi,
   output logic [CTRL_W-1:0]   rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_en  <= 1'b0;
         card_en <= 1'b0;
         div_lo  <= '0;
         div_hi  <= '0;
      end else if (wr_en) begin
         int_en  <= wr_data[POS_INT_EN];
         card_en <= wr_data[POS_CARD_EN];
         div_lo  <= wr_data[POS_DIV_LO +: DIV_LO_W];
         div_hi  <= wr_data[POS_DIV_HI +: DIV_HI_W];
      end
   end

   always_comb begin
      rd_data                           = '0;
      rd_data[POS_INT_EN]               = int_en;
      rd_data[POS_STABLE]               = stable_in;
      rd_data[POS_CARD_EN]              = card_en;
      rd_data[POS_DIV_HI +: DIV_HI_W]   = div_hi;
      rd_data[POS_DIV_LO +: DIV_LO_W]   = div_lo;
   end
endmodule

// File: rtl/cardclk_stab.sv
module cardclk_stab #(
   parameter int STABLE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic stable
);
   localparam int CW = $clog2(STABLE_CYCLES + 1);

   logic [CW-1:0] cnt;
   logic          st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         st_q <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         st_q <= 1'b0;
      end else if (!st_q) begin
         cnt <= cnt + CW'(1);
         if (cnt == CW'(STABLE_CYCLES - 1))
            st_q <= 1'b1;
      end
   end

   // falls in the same cycle the enable is cleared
   assign stable = st_q & en;
endmodule

// File: rtl/cardclk_divsel.sv
module cardclk_divsel
   import cardclk_pkg::*;
#(
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic                ext_mode,
   input  logic [DIV_LO_W-1:0] div_lo,
   input  logic [DIV_HI_W-1:0] div_hi,
   output logic [DIV_W-1:0]    half
);
   generate
      if (LEGACY_EN) begin : g_dual
         logic [DIV_W-1:0] leg;
         always_comb begin
            leg = '0;
            for (int i = 0; i < DIV_LO_W; i++)
               if (div_lo[i]) leg = DIV_W'(1) << i;
         end
         assign half = ext_mode ? {div_hi, div_lo} : leg;
      end else begin : g_ext_only
         logic unused_mode;
         assign unused_mode = ext_mode;
         assign half = {div_hi, div_lo};
      end
   endgenerate
endmodule

// File: rtl/cardclk_divgen.sv
module cardclk_divgen
   import cardclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_on,
   input  logic [DIV_W-1:0] half_req,
   output logic             card_clk,
   output logic             div_lvl,
   output logic [DIV_W-1:0] half_run
);
   logic [DIV_W-1:0] h_cur;
   logic [DIV_W-1:0] cnt;
   logic             div_q;
   logic             idle_q;
   logic             byp_req;
   logic             byp_g;
   logic             last;

   assign last = (cnt == h_cur - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cur   <= '0;
         cnt     <= '0;
         div_q   <= 1'b0;
         idle_q  <= 1'b1;
         byp_req <= 1'b0;
      end else if (div_q) begin
         if (last) begin
            div_q <= 1'b0;
            cnt   <= '0;
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end else if (idle_q || (h_cur == '0) || last) begin
         // end of a low phase: the only point where the divisor is reloaded
         h_cur <= half_req;
         cnt   <= '0;
         if (gate_on) begin
            idle_q <= 1'b0;
            if (half_req == '0) begin
               byp_req <= 1'b1;
            end else begin
               byp_req <= 1'b0;
               div_q   <= 1'b1;
            end
         end else begin
            idle_q  <= 1'b1;
            byp_req <= 1'b0;
         end
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   // pass-through gate moves only while the base clock is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) byp_g <= 1'b0;
      else        byp_g <= byp_req;
   end

   assign card_clk = div_q | (clk & byp_g);
   assign div_lvl  = div_q;
   assign half_run = h_cur;
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
   import cardclk_pkg::*;
#(
   parameter int STABLE_CYCLES = 8,
   parameter bit LEGACY_EN     = 1'b1
) (
   input  logic              clk_base,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   output logic              card_clk
);
   generate
      if (STABLE_CYCLES < 1) begin : g_bad_stable
         $error("cardclk_gen: STABLE_CYCLES must be at least 1");
      end
      if (POS_DIV_LO + DIV_LO_W > CTRL_W) begin : g_bad_layout
         $error("cardclk_gen: divisor field exceeds control width");
      end
   endgenerate

   logic                int_en;
   logic                card_en;
   logic                stable;
   logic                gate_on;
   logic [DIV_LO_W-1:0] div_lo;
   logic [DIV_HI_W-1:0] div_hi;
   logic [DIV_W-1:0]    half_req;
   logic [DIV_W-1:0]    half_run;
   logic                div_lvl;

   cardclk_regs u_regs (
      .clk       (clk_base),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .stable_in (stable),
      .int_en    (int_en),
      .card_en   (card_en),
      .div_lo    (div_lo),
      .div_hi    (div_hi),
      .rd_data   (rd_data)
   );

   cardclk_stab #(.STABLE_CYCLES(STABLE_CYCLES)) u_stab (
      .clk    (clk_base),
      .rst_n  (rst_n),
      .en     (int_en),
      .stable (stable)
   );

   cardclk_divsel #(.LEGACY_EN(LEGACY_EN)) u_divsel (
      .ext_mode (ext_mode),
      .div_lo   (div_lo),
      .div_hi   (div_hi),
      .half     (half_req)
   );

   assign gate_on = stable & card_en;

   cardclk_divgen u_divgen (
      .clk      (clk_base),
      .rst_n    (rst_n),
      .gate_on  (gate_on),
      .half_req (half_req),
      .card_clk (card_clk),
      .div_lvl  (div_lvl),
      .half_run (half_run)
   );
endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk
   import cardclk_pkg::*;
#(
   parameter int STABLE_CYCLES = 8
) (
   input logic              clk_base,
   input logic              rst_n,
   input logic              wr_en,
   input logic [CTRL_W-1:0] wr_data,
   input logic [CTRL_W-1:0] rd_data,
   input logic              gate_on,
   input logic              div_lvl,
   input logic [DIV_W-1:0]  half_run
);
   localparam int CW = $clog2(STABLE_CYCLES + 1);

   logic [CW-1:0] en_cnt;
   logic [DIV_W:0] hi_cnt;
   logic           past_ok;

   always_ff @(posedge clk_base or negedge rst_n) begin
      if (!rst_n) begin
         en_cnt  <= '0;
         hi_cnt  <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (!rd_data[POS_INT_EN])             en_cnt <= '0;
         else if (en_cnt != CW'(STABLE_CYCLES)) en_cnt <= en_cnt + CW'(1);
         hi_cnt <= div_lvl ? hi_cnt + (DIV_W+1)'(1) : '0;
      end
   end

   assert_stable_early_R3: assert property (@(posedge clk_base) disable iff (!rst_n)
      rd_data[POS_STABLE] |-> (en_cnt == CW'(STABLE_CYCLES)));

   assert_stable_late_R3: assert property (@(posedge clk_base) disable iff (!rst_n)
      (rd_data[POS_INT_EN] && en_cnt == CW'(STABLE_CYCLES)) |-> rd_data[POS_STABLE]);

   assert_stable_drop_R4: assert property (@(posedge clk_base) disable iff (!rst_n)
      (past_ok && $past(wr_en && !wr_data[POS_INT_EN])) |-> !rd_data[POS_STABLE]);

   assert_gated_start_R5: assert property (@(posedge clk_base) disable iff (!rst_n)
      (past_ok && $rose(div_lvl)) |-> $past(gate_on));

   assert_full_high_R10: assert property (@(posedge clk_base) disable iff (!rst_n)
      (past_ok && $fell(div_lvl)) |-> (hi_cnt == {1'b0, half_run}));

   assert_divisor_hold_R10: assert property (@(posedge clk_base) disable iff (!rst_n)
      (past_ok && half_run != $past(half_run)) |-> !$past(div_lvl));

   assert_zero_clear_R11: assert property (@(posedge clk_base) disable iff (!rst_n)
      (past_ok && $past(wr_en && wr_data == '0)) |-> (rd_data == '0));
endmodule

bind cardclk_gen cardclk_gen_chk #(.STABLE_CYCLES(STABLE_CYCLES)) u_chk (
   .clk_base (clk_base),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .gate_on  (gate_on),
   .div_lvl  (div_lvl),
   .half_run (half_run)
);

// File: tb/cardclk_gen_bench.sv
module cardclk_gen_bench;
   localparam int S = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        card_clk;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cardclk_gen #(.STABLE_CYCLES(S), .LEGACY_EN(1'b1)) u_cardclk_gen (
      .clk_base (clk),
      .rst_n    (rst_n),
      .ext_mode (ext_mode),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .card_clk (card_clk)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(posedge clk); #1;
      wr_en   = 1'b0;
   endtask

   function automatic logic [15:0] mk(input int n, input bit ie, input bit ce);
      logic [9:0] v;
      v  = n[9:0];
      mk = {v[7:0], v[9:8], 3'b000, ce, 1'b0, ie};
   endfunction

   task automatic bringup(input int n, input bit ext);
      int guard;
      ext_mode = ext;
      wr(mk(n, 1'b1, 1'b0));
      guard = 0;
      while (!rd_data[1] && guard < 100) begin tick(); guard++; end
      wr(mk(n, 1'b1, 1'b1));
   endtask

   task automatic stop_all();
      wr(16'h0000);
      repeat (2100) tick();
   endtask

   task automatic meas(output int hi, output int lo);
      int guard;
      guard = 0;
      while (card_clk !== 1'b0 && guard < 20000) begin tick(); guard++; end
      while (card_clk !== 1'b1 && guard < 20000) begin tick(); guard++; end
      hi = 0;
      while (card_clk === 1'b1 && guard < 20000) begin hi++; tick(); guard++; end
      lo = 0;
      while (card_clk === 1'b0 && guard < 20000) begin lo++; tick(); guard++; end
   endtask

   task automatic check_bypass(input string req);
      int bad;
      bad = 0;
      repeat (4) tick();
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); #1;
         if (card_clk !== 1'b1) bad++;
         @(negedge clk); #1;
         if (card_clk !== 1'b0) bad++;
      end
      check(bad == 0, req, bad, 0);
   endtask

   task automatic t_reset();
      check(rd_data == 16'h0000, "R1 readback", rd_data, 0);
      check(card_clk === 1'b0, "R1 card_clk", card_clk, 0);
   endtask

   task automatic t_layout();
      int high_seen;
      ext_mode = 1'b1;
      wr(16'hA5BA);
      check(rd_data == 16'hA580, "R2 layout", rd_data, 16'hA580);
      high_seen = 0;
      repeat (20) begin tick(); if (card_clk !== 1'b0) high_seen++; end
      check(high_seen == 0, "R2 no clock without enables", high_seen, 0);
      stop_all();
   endtask

   task automatic t_stable();
      int k, early;
      ext_mode = 1'b1;
      wr(mk(1, 1'b1, 1'b1));
      k = 0; early = 0;
      while (!rd_data[1] && k < 100) begin
         if (card_clk !== 1'b0) early++;
         tick(); k++;
      end
      check(k == S, "R3 stable delay", k, S);
      check(early == 0, "R5 card clock held before stable", early, 0);
   endtask

   task automatic t_drop();
      wr(mk(1, 1'b0, 1'b0));
      check(rd_data[1] == 1'b0, "R4 stable drops at once", rd_data[1], 0);
      check(rd_data == mk(1, 1'b0, 1'b0), "R4 readback", rd_data, mk(1, 1'b0, 1'b0));
      stop_all();
   endtask

   task automatic t_ext(input int n);
      int hi, lo;
      bringup(n, 1'b1);
      meas(hi, lo);
      check(hi == n, "R6 high phase", hi, n);
      check(lo == n, "R6 low phase", lo, n);
      stop_all();
   endtask

   task automatic t_bypass_ext();
      bringup(0, 1'b1);
      check_bypass("R7 pass-through");
      stop_all();
   endtask

   task automatic t_legacy();
      int hi, lo;
      bringup(16'h308, 1'b0);
      meas(hi, lo);
      check(hi == 8 && lo == 8, "R8 legacy hi part ignored", hi, 8);
      stop_all();
      bringup(16'h300, 1'b0);
      check_bypass("R8 legacy zero pass-through");
      stop_all();
   endtask

   task automatic t_round(input int f, input int exp);
      int hi, lo;
      bringup(f, 1'b0);
      meas(hi, lo);
      check(hi == exp, "R9 rounded high", hi, exp);
      check(lo == exp, "R9 rounded low", lo, exp);
      stop_all();
   endtask

   task automatic t_change();
      int hi, lo, guard;
      bringup(3, 1'b1);
      meas(hi, lo);
      guard = 0;
      while (card_clk !== 1'b0 && guard < 100) begin tick(); guard++; end
      while (card_clk !== 1'b1 && guard < 100) begin tick(); guard++; end
      wr(mk(5, 1'b1, 1'b1));
      while (card_clk === 1'b1 && guard < 200) begin tick(); guard++; end
      lo = 0;
      while (card_clk === 1'b0 && guard < 200) begin lo++; tick(); guard++; end
      hi = 0;
      while (card_clk === 1'b1 && guard < 200) begin hi++; tick(); guard++; end
      check(lo == 3, "R10 low phase keeps old length", lo, 3);
      check(hi == 5, "R10 next high takes new length", hi, 5);
      stop_all();
   endtask

   task automatic t_stop();
      int hi, lo, bad;
      bringup(3, 1'b1);
      meas(hi, lo);
      wr(16'h0000);
      check(rd_data == 16'h0000, "R11 readback cleared", rd_data, 0);
      repeat (4) tick();
      bad = 0;
      repeat (12) begin if (card_clk !== 1'b0) bad++; tick(); end
      check(bad == 0, "R11 card clock stopped", bad, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_layout();
      t_stable();
      t_drop();
      t_ext(1);
      t_ext(3);
      t_ext(258);
      t_bypass_ext();
      t_legacy();
      t_round(16'h06, 4);
      t_round(16'h81, 128);
      t_change();
      t_stop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule